// File: doc/BRIEF.md
# External Event Timestamp Capture

This block records the free-running 64-bit time value whenever a rising edge arrives on one of two asynchronous trigger inputs. Each trigger goes through a synchroniser and an edge detector. Every detected edge is written into that channel's own store, which is a small first-in first-out queue. The queue depth is set per channel, and a depth of one gives a single-capture holding register.

Software reaches the block through a simple word-wide register port. It polls a status word for a per-channel "data waiting" flag. It then reads each stamp as a low word followed by a high word, and the high-word read removes the entry. Each detected edge also raises a per-channel event flag. The event flags are combined with an interrupt mask to drive a single interrupt line. Event flags are cleared by writing ones to them. The enable command arms a channel: it sets the channel's mask bit and clears any stale event flag. The disable command only clears the mask bit.

Top module: `ext_stamp_unit`

## Requirements
- R1: Each trigger input passes through a synchroniser of SYNC_STAGES flops (default 2), and only a 0-to-1 transition is captured. If a trigger is first sampled high at clock edge k, the stored stamp equals `time_now` as sampled at edge k+SYNC_STAGES. Holding the input high, or letting it fall, stores nothing more.
- R2: For channel c, reading address 8+2c returns bits 31:0 of the oldest stamp, or 0 if the queue is empty, and latches bits 63:32 (0 when empty). Reading address 9+2c returns the latched word and removes the oldest entry if one is present. `reg_rdata` is updated on the clock edge that samples `reg_rd`.
- R3: Channel 0 holds up to DEPTH0 stamps and channel 1 holds up to DEPTH1 stamps, read back oldest first. An edge that arrives while the queue is full is dropped and sets the sticky overflow bit, bit 2+c of the status word at address 2. Writing 1 to that bit clears it.
- R4: Status bit c (address 2) is 1 exactly while channel c holds at least one unread stamp.
- R5: Event word (address 0) bit c is set by every detected edge on channel c, dropped edges included. Writing 1 to a bit clears it, and a new edge in the same cycle wins over the clear.
- R6: The mask word (address 1, bits 1:0) can be read and written. `irq` is the OR of (event AND mask), registered once.
- R7: Writing address 3 with bit c set sets mask bit c and clears event bit c. Writing address 4 with bit c set clears mask bit c and leaves the event word unchanged.
- R8: After reset, the status, event and mask words read 0, `irq` is low, and both queues are empty.
- R9: The two channels are independent. Captures, reads and clears on one channel never alter the stamps, status or event bit of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current time value to be captured |
| trig_in | input | 2 | Asynchronous trigger inputs, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Assertions check several properties on every cycle:
- the edge detector never produces a pulse two cycles in a row;
- a queue's fill level never exceeds its depth and does not move when the queue is empty and idle;
- an overflow flag stays set until its clear is written;
- each capture pulse leaves its event bit set on the next cycle;
- `irq` stays low when no unmasked event exists;
- a disable command clears the mask without touching the events.

Only the bench scenarios can show the rest: the exact stamp values and the capture latency, oldest-first read order, the pairing of the low and high words across the 32-bit carry, dropping when a queue is full, and that the channels do not interfere with each other.

// File: rtl/ets_pkg.sv
package ets_pkg;
  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned STAMP_W = 64;
  localparam int unsigned DATA_W  = 32;

  localparam int unsigned ADR_EVENT   = 0;
  localparam int unsigned ADR_MASK    = 1;
  localparam int unsigned ADR_STATUS  = 2;
  localparam int unsigned ADR_ENABLE  = 3;
  localparam int unsigned ADR_DISABLE = 4;
  localparam int unsigned ADR_STAMP0  = 8;
endpackage

// File: rtl/ets_sync_edge.sv
module ets_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;

  // R1: a held-high input yields one capture pulse only
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/ets_stamp_fifo.sv
module ets_stamp_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         valid,
  output logic         drop
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign valid   = (cnt != '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & valid;
  assign drop    = push & full;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= adv(wp);
      if (do_pop)  rp <= adv(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R3: fill level bounded by the depth
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R3: a capture into a full queue leaves it full
  p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);
  // R2: an idle empty queue stays empty
  p_empty_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!valid && !push) |=> !valid);
endmodule

// File: rtl/ext_stamp_unit.sv
module ext_stamp_unit
  import ets_pkg::*;
#(
  parameter int unsigned DEPTH0      = 4,
  parameter int unsigned DEPTH1      = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STAMP_W-1:0]  time_now,
  input  logic [NUM_CH-1:0]   trig_in,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq
);
  localparam int unsigned HALF = STAMP_W / 2;

  logic [NUM_CH-1:0]  cap, vld, drop, pop, rd_lo;
  logic [STAMP_W-1:0] head [NUM_CH];
  logic [HALF-1:0]    hi_latch [NUM_CH];
  logic [NUM_CH-1:0]  ev_q, mask_q, ovf_q;
  logic [NUM_CH-1:0]  wbits, ev_clr, en_set, dis_set, ovf_clr;
  logic               wr_ev, wr_mask, wr_stat, wr_en, wr_dis;
  logic [DATA_W-1:0]  rd_val;
  int unsigned        a;

  assign a       = int'(reg_addr);
  assign wbits   = reg_wdata[NUM_CH-1:0];
  assign wr_ev   = reg_wr && (a == ADR_EVENT);
  assign wr_mask = reg_wr && (a == ADR_MASK);
  assign wr_stat = reg_wr && (a == ADR_STATUS);
  assign wr_en   = reg_wr && (a == ADR_ENABLE);
  assign wr_dis  = reg_wr && (a == ADR_DISABLE);
  assign en_set  = wr_en  ? wbits : '0;
  assign dis_set = wr_dis ? wbits : '0;
  assign ev_clr  = (wr_ev ? wbits : '0) | en_set;
  assign ovf_clr = wr_stat ? reg_wdata[2*NUM_CH-1:NUM_CH] : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int unsigned D = (g == 0) ? DEPTH0 : DEPTH1;

    assign pop[g]   = reg_rd && (a == ADR_STAMP0 + 2*g + 1);
    assign rd_lo[g] = reg_rd && (a == ADR_STAMP0 + 2*g);

    ets_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst(rst), .din(trig_in[g]), .rise(cap[g])
    );

    ets_stamp_fifo #(.DEPTH(D), .W(STAMP_W)) i_fifo (
      .clk(clk), .rst(rst), .push(cap[g]), .din(time_now),
      .pop(pop[g]), .head(head[g]), .valid(vld[g]), .drop(drop[g])
    );

    always_ff @(posedge clk) begin
      if (rst)           hi_latch[g] <= '0;
      else if (rd_lo[g]) hi_latch[g] <= vld[g] ? head[g][STAMP_W-1:HALF] : '0;
    end

    // R5: a capture pulse always leaves its event bit set
    p_event_on_capture_r5: assert property (@(posedge clk) disable iff (rst)
      cap[g] |=> ev_q[g]);
    // R7: disable clears the mask bit
    p_disable_mask_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_dis && wbits[g]) |=> !mask_q[g]);
    // R3: overflow stays until cleared
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      (ovf_q[g] && !ovf_clr[g]) |=> ovf_q[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= '0;
      mask_q <= '0;
      ovf_q  <= '0;
      irq    <= 1'b0;
    end else begin
      ev_q  <= (ev_q & ~ev_clr) | cap;
      ovf_q <= (ovf_q & ~ovf_clr) | drop;
      if (wr_mask) mask_q <= wbits;
      else         mask_q <= (mask_q | en_set) & ~dis_set;
      irq <= |(ev_q & mask_q);
    end
  end

  always_comb begin
    rd_val = '0;
    case (a)
      ADR_EVENT:  rd_val[NUM_CH-1:0] = ev_q;
      ADR_MASK:   rd_val[NUM_CH-1:0] = mask_q;
      ADR_STATUS: rd_val[2*NUM_CH-1:0] = {ovf_q, vld};
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (a == ADR_STAMP0 + 2*c)
            rd_val = vld[c] ? head[c][HALF-1:0] : '0;
          else if (a == ADR_STAMP0 + 2*c + 1)
            rd_val = hi_latch[c];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  // R6: no unmasked event means no interrupt next cycle
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    ((ev_q & mask_q) == '0) |=> !irq);
  // R7: a disable command alone does not touch the event word
  p_disable_keeps_event_r7: assert property (@(posedge clk) disable iff (rst)
    wr_dis |=> (ev_q == ($past(ev_q) | $past(cap))));
endmodule

// File: tb/test_ext_stamp_unit.sv
module test_ext_stamp_unit;
  localparam int D0  = 4;
  localparam int D1  = 1;
  localparam int INC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] tnow = 64'h0000_0001_FFFF_FF80;
  logic [1:0]  trig = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [63:0] mq0[$];
  logic [63:0] mq1[$];
  logic [1:0]  m_ev = '0, m_mask = '0, m_ovf = '0;

  always #2 clk = ~clk;
  always @(posedge clk) tnow <= tnow + INC;

  ext_stamp_unit #(.DEPTH0(D0), .DEPTH1(D1)) i_ext_stamp_unit (
    .clk(clk), .rst(rst), .time_now(tnow), .trig_in(trig),
    .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int ad, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = 4'(ad); wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input int ad, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = 4'(ad);
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  function automatic int qsize(input int ch);
    return (ch == 0) ? mq0.size() : mq1.size();
  endfunction

  task automatic pulse(input int ch);
    logic [63:0] st;
    @(negedge clk);
    trig[ch] = 1'b1;
    st = tnow + 64'(2*INC);
    m_ev[ch] = 1'b1;
    if (ch == 0) begin if (mq0.size() < D0) mq0.push_back(st); else m_ovf[0] = 1'b1; end
    else         begin if (mq1.size() < D1) mq1.push_back(st); else m_ovf[1] = 1'b1; end
    repeat (5) @(negedge clk);
    trig[ch] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_stamp(input int ch, input string req);
    logic [31:0] d;
    logic [63:0] e;
    e = 64'd0;
    if (qsize(ch) > 0) e = (ch == 0) ? mq0[0] : mq1[0];
    reg_read(8 + 2*ch, d);
    check(req, 64'(d), 64'(e[31:0]));
    reg_read(9 + 2*ch, d);
    check(req, 64'(d), 64'(e[63:32]));
    if (ch == 0) begin if (mq0.size() > 0) void'(mq0.pop_front()); end
    else         begin if (mq1.size() > 0) void'(mq1.pop_front()); end
  endtask

  task automatic check_status(input string req);
    logic [31:0] d;
    logic [1:0] v;
    v = {qsize(1) > 0, qsize(0) > 0};
    reg_read(2, d);
    check(req, 64'(d), 64'({m_ovf, v}));
  endtask

  task automatic check_event(input string req);
    logic [31:0] d;
    reg_read(0, d);
    check(req, 64'(d), 64'(m_ev));
  endtask

  task automatic check_irq(input string req);
    repeat (2) @(negedge clk);
    check(req, 64'(irq), 64'(|(m_ev & m_mask)));
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int seed;
    seed = $urandom(32'd1234);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8: reset state
    check("R8 irq", 64'(irq), 64'd0);
    check_status("R8 status");
    check_event("R8 event");
    reg_read(1, d); check("R8 mask", 64'(d), 64'd0);
    read_stamp(0, "R8 empty stamp");

    // R7: enable ch0 sets mask; R1/R5/R6 capture raises event and irq
    reg_write(3, 32'h1); m_mask[0] = 1'b1; m_ev[0] = 1'b0;
    reg_read(1, d); check("R7 enable mask", 64'(d), 64'd1);
    pulse(0);
    check_event("R5 event set");
    check_irq("R6 irq raised");
    check_status("R4 valid ch0");

    // R3: fill ch0 and overflow it
    for (int i = 0; i < D0; i++) pulse(0);
    check_status("R3 overflow ch0");
    for (int i = 0; i < D0; i++) read_stamp(0, "R2 R3 order ch0");
    read_stamp(0, "R2 empty read");
    check_status("R4 cleared ch0");

    // R3/R9: depth-one channel drops second edge, ch0 unaffected
    pulse(1); pulse(1);
    check_status("R3 R9 overflow ch1");
    read_stamp(1, "R1 single hold ch1");
    reg_write(2, 32'h8); m_ovf[1] = 1'b0;
    check_status("R3 clear ovf ch1");
    reg_write(2, 32'h4); m_ovf[0] = 1'b0;
    check_status("R3 clear ovf ch0");

    // R5/R9: W1C on ch0 leaves ch1
    reg_write(0, 32'h1); m_ev[0] = 1'b0;
    check_event("R5 R9 w1c");
    check_irq("R6 irq after clear");

    // R7: disable keeps event
    pulse(0);
    reg_write(4, 32'h1); m_mask[0] = 1'b0;
    check_event("R7 disable keeps event");
    check_irq("R7 irq masked");
    read_stamp(0, "R2 stamp after disable");

    // Random phase
    for (int it = 0; it < 80; it++) begin
      int op, ch;
      op = int'($urandom_range(0, 5));
      ch = int'($urandom_range(0, 1));
      case (op)
        0, 1: pulse(ch);
        2: read_stamp(ch, "R2 R9 random read");
        3: begin
             logic [1:0] b;
             b = 2'($urandom_range(0, 3));
             reg_write(0, 32'(b)); m_ev = m_ev & ~b;
           end
        4: begin reg_write(3, 32'(1 << ch)); m_mask[ch] = 1'b1; m_ev[ch] = 1'b0; end
        default: begin reg_write(4, 32'(1 << ch)); m_mask[ch] = 1'b0; end
      endcase
      check_status("R3 R4 random status");
      check_event("R5 random event");
      check_irq("R6 random irq");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule